// File: doc/BRIEF.md
# Memory Protection Region Checker

This block judges every bus access against eight programmable protection regions. Each region has an aligned base address, a power-of-two size, an enable bit, and an eight-bit mask that removes individual eighths of the region from matching. Each region also carries memory-type bits (type-extension, shareable, C and B), a three-bit access-permission code and an execute-never bit. An access presents its address and three flags: write, privileged and instruction fetch. One clock later the block reports whether a region claimed the access, which region it was, the decoded memory type and shareability, and whether the access must be refused.

Regions may overlap, and the highest-numbered region that claims an address wins. Masking an eighth of a high-numbered region lets a lower-numbered region that covers the same addresses supply the attributes there. When no region claims an address and protection is on, privileged accesses fall through to a plain background map. Unprivileged accesses are refused in that case. Software writes region settings through a simple write port, one 32-bit word at a time.

Top module: `mpu_region_check`

## Requirements
- R1: The write port stores `cfg_wdata` into region `cfg_region` when `cfg_we` is high. With `cfg_field`=0 it stores the base address: bits 31:5 are kept and bits 4:0 are ignored. With `cfg_field`=1 it stores the attribute word: enable at bit 0, SIZE at 5:1, subregion mask at 15:8, B at 16, C at 17, S at 18, TEX at 21:19, AP at 26:24 and XN at 28. An enabled region covers 2^(SIZE+1) bytes starting at its base with the low SIZE+1 bits cleared.
- R2: An access sampled with `acc_valid` high produces its result on the outputs after the next rising edge, and `res_valid` is high for exactly that cycle.
- R3: When several enabled regions claim an address, the highest-numbered one is reported on `res_region` and supplies the attributes.
- R4: For SIZE of 7 or more (256 bytes and up), mask bit i removes the i-th eighth of the region from matching, counting from the lowest address. A lower-numbered overlapping region then claims those addresses. For smaller regions the mask is ignored.
- R5: TEX=000 decodes as follows, with `res_mtype` encoded as 0 normal, 1 device, 2 strongly ordered and 3 reserved. C,B=00 gives strongly ordered, shareable. C,B=01 gives device, shareable. In both of these cases S is ignored. C=1 gives normal memory with shareability equal to S.
- R6: TEX=001 with C,B=00 or 11 gives normal memory with shareability equal to S. TEX=010 with C,B=00 gives non-shareable device memory. TEX=001 with C,B=01 or 10, TEX=010 with any other C,B, and TEX=011 are all reserved and report a non-shareable result.
- R7: TEX values 100 to 111 give normal memory with shareability equal to S, for any C and B.
- R8: A reserved encoding in the winning region raises `res_fault`.
- R9: The AP code governs access as follows. Code 000 and code 100 allow no access. Code 001 allows privileged read/write only. Code 010 allows privileged read/write and unprivileged read. Code 011 allows all accesses. Code 101 allows privileged read only. Codes 110 and 111 allow reads at either level. A disallowed access raises `res_fault`. An instruction fetch counts as a read.
- R10: An instruction fetch that hits a region with XN=1 raises `res_fault`. Data accesses are not affected by XN.
- R11: With `mpu_enable` high and no region claiming the address, `res_hit` is 0, `res_region` is 0, and the type is normal and non-shareable. `res_fault` equals the inverse of the privileged flag.
- R12: With `mpu_enable` low, every access reports no hit, no fault, region 0, and normal non-shareable memory.
- R13: When a region write and an access fall in the same cycle, the access is judged by the settings that were in force before that write.
- R14: After reset, all regions are disabled and every result output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mpu_enable | input | 1 | Protection on |
| cfg_we | input | 1 | Region register write strobe |
| cfg_region | input | 3 | Region index to write |
| cfg_field | input | 1 | 0 base word, 1 attribute word |
| cfg_wdata | input | 32 | Write data |
| acc_valid | input | 1 | Access present this cycle |
| acc_addr | input | 32 | Access address |
| acc_write | input | 1 | Access is a write |
| acc_priv | input | 1 | Access is privileged |
| acc_fetch | input | 1 | Access is an instruction fetch |
| res_valid | output | 1 | Result present |
| res_hit | output | 1 | A region claimed the access |
| res_region | output | 3 | Winning region index |
| res_mtype | output | 2 | Decoded memory type |
| res_shareable | output | 1 | Decoded shareability |
| res_fault | output | 1 | Access refused |

## Verification
A region write and a lookup can be presented in the same cycle. This happens when software reprograms a region while traffic keeps flowing. The bench provokes the collision by disabling a live region at the very cycle an access targets it, and expects the old settings to judge that access. On the following cycle it repeats the same access and expects a miss. Random rounds also overlap many regions with partial masks, so priority, subregion fall-through and attribute decode meet in single lookups. Each result is compared with a bench model built from the requirements.

// File: rtl/mpu_pkg.sv
// Shared types and decode functions for the protection region checker.
// Assumes a 32-bit address space and 32-byte minimum base granularity.
package mpu_pkg;

    localparam int ADDR_W       = 32;
    localparam int SIZE_W       = 5;
    localparam int SUB_N        = 8;
    localparam int SUB_MIN_SIZE = 7;   // 2^(7+1) = 256 bytes
    localparam int BASE_LSB     = 5;

    // Attribute word bit positions (software-visible layout)
    localparam int A_EN   = 0;
    localparam int A_SIZE = 1;
    localparam int A_SRD  = 8;
    localparam int A_B    = 16;
    localparam int A_C    = 17;
    localparam int A_S    = 18;
    localparam int A_TEX  = 19;
    localparam int A_AP   = 24;
    localparam int A_XN   = 28;

    typedef enum logic [1:0] {
        MT_NORMAL   = 2'd0,
        MT_DEVICE   = 2'd1,
        MT_STRONG   = 2'd2,
        MT_RESERVED = 2'd3
    } mem_type_e;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic              en;
        logic [SIZE_W-1:0] size;
        logic [SUB_N-1:0]  srd;
        logic              b;
        logic              c;
        logic              s;
        logic [2:0]        tex;
        logic [2:0]        ap;
        logic              xn;
    } region_cfg_t;

    typedef struct packed {
        mem_type_e mtype;
        logic      shareable;
    } mem_attr_t;

    // Map TEX/C/B/S onto memory type and shareability
    function automatic mem_attr_t decode_attr(logic [2:0] tex, logic c, logic b, logic s);
        mem_attr_t res;
        res.mtype     = MT_RESERVED;
        res.shareable = 1'b0;
        if (tex[2]) begin
            res.mtype     = MT_NORMAL;
            res.shareable = s;
        end else begin
            case ({tex[1:0], c, b})
                4'b0000: begin res.mtype = MT_STRONG; res.shareable = 1'b1; end
                4'b0001: begin res.mtype = MT_DEVICE; res.shareable = 1'b1; end
                4'b0010,
                4'b0011,
                4'b0100,
                4'b0111: begin res.mtype = MT_NORMAL; res.shareable = s; end
                4'b1000: begin res.mtype = MT_DEVICE; res.shareable = 1'b0; end
                default: begin res.mtype = MT_RESERVED; res.shareable = 1'b0; end
            endcase
        end
        return res;
    endfunction

    // True when the AP code admits this access
    function automatic logic ap_permits(logic [2:0] ap, logic wr, logic priv);
        logic ok;
        case (ap)
            3'b001:         ok = priv;
            3'b010:         ok = priv || !wr;
            3'b011:         ok = 1'b1;
            3'b101:         ok = priv && !wr;
            3'b110, 3'b111: ok = !wr;
            default:        ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/mpu_cfg_regs.sv
// Region register file. One 32-bit word per write, selected by region
// index and field. Assumes cfg_region values at or above NUM_REGIONS are
// dropped.
module mpu_cfg_regs
    import mpu_pkg::*;
#(
    parameter int NUM_REGIONS = 8,
    parameter int IDX_W       = 3
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               cfg_we,
    input  logic [IDX_W-1:0]                   cfg_region,
    input  logic                               cfg_field,
    input  logic [31:0]                        cfg_wdata,
    output region_cfg_t [NUM_REGIONS-1:0]      regions
);

    logic unused_wbits;
    assign unused_wbits = ^{cfg_wdata[BASE_LSB-1:0], cfg_wdata[7:6],
                            cfg_wdata[23:22], cfg_wdata[27], cfg_wdata[31:29]};

    for (genvar gr = 0; gr < NUM_REGIONS; gr++) begin : g_region
        region_cfg_t q;

        // Capture base or attribute word for this region
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= '0;
            end else if (cfg_we && cfg_region == IDX_W'(gr)) begin
                if (!cfg_field) begin
                    q.base <= {cfg_wdata[ADDR_W-1:BASE_LSB], {BASE_LSB{1'b0}}};
                end else begin
                    q.en   <= cfg_wdata[A_EN];
                    q.size <= cfg_wdata[A_SIZE +: SIZE_W];
                    q.srd  <= cfg_wdata[A_SRD +: SUB_N];
                    q.b    <= cfg_wdata[A_B];
                    q.c    <= cfg_wdata[A_C];
                    q.s    <= cfg_wdata[A_S];
                    q.tex  <= cfg_wdata[A_TEX +: 3];
                    q.ap   <= cfg_wdata[A_AP +: 3];
                    q.xn   <= cfg_wdata[A_XN];
                end
            end
        end

        assign regions[gr] = q;
    end

endmodule

// File: rtl/mpu_region_match.sv
// Address match for one region: aligned range compare plus subregion mask.
// Assumes the base is read as aligned to the region size; the mask only
// counts for regions of 256 bytes or more.
module mpu_region_match
    import mpu_pkg::*;
(
    input  region_cfg_t       cfg,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);

    logic [5:0]        span_sh;
    logic [ADDR_W-1:0] keep_mask;
    logic              in_range;
    logic [2:0]        sub_idx;
    logic              sub_off;

    logic unused_fields;
    assign unused_fields = ^{cfg.b, cfg.c, cfg.s, cfg.tex, cfg.ap, cfg.xn};

    // Range compare on the bits above the region size, then subregion test
    always_comb begin
        span_sh   = {1'b0, cfg.size} + 6'd1;
        keep_mask = {ADDR_W{1'b1}} << span_sh;
        in_range  = ((addr ^ cfg.base) & keep_mask) == '0;
        sub_idx   = 3'(addr >> (span_sh - 6'd3));
        sub_off   = (cfg.size >= SIZE_W'(SUB_MIN_SIZE)) && cfg.srd[sub_idx];
        hit       = cfg.en && in_range && !sub_off;
    end

endmodule

// File: rtl/mpu_attr_check.sv
// Picks the winning region, decodes its attributes and judges permission.
// Assumes the highest-numbered claiming region has priority.
module mpu_attr_check
    import mpu_pkg::*;
#(
    parameter int NUM_REGIONS = 8,
    parameter int IDX_W       = 3
) (
    input  region_cfg_t [NUM_REGIONS-1:0] regions,
    input  logic [NUM_REGIONS-1:0]        hits,
    input  logic                          enable,
    input  logic                          acc_write,
    input  logic                          acc_priv,
    input  logic                          acc_fetch,
    output logic                          out_hit,
    output logic [IDX_W-1:0]              out_region,
    output mem_type_e                     out_mtype,
    output logic                          out_shareable,
    output logic                          out_fault
);

    logic [IDX_W-1:0] win;
    logic             any;
    region_cfg_t      sel;
    mem_attr_t        attr;
    logic             eff_write;
    logic             perm_ok;

    logic unused_regs;
    assign unused_regs = ^regions;

    // Priority select: later (higher) regions overwrite earlier ones
    always_comb begin
        win = '0;
        any = 1'b0;
        for (int r = 0; r < NUM_REGIONS; r++) begin
            if (hits[r]) begin
                win = IDX_W'(r);
                any = 1'b1;
            end
        end
    end

    // Decode winner attributes and form the result
    always_comb begin
        sel       = regions[win];
        attr      = decode_attr(sel.tex, sel.c, sel.b, sel.s);
        eff_write = acc_write && !acc_fetch;
        perm_ok   = ap_permits(sel.ap, eff_write, acc_priv);

        out_hit       = 1'b0;
        out_region    = '0;
        out_mtype     = MT_NORMAL;
        out_shareable = 1'b0;
        out_fault     = 1'b0;
        if (enable) begin
            if (any) begin
                out_hit       = 1'b1;
                out_region    = win;
                out_mtype     = attr.mtype;
                out_shareable = attr.shareable;
                out_fault     = (attr.mtype == MT_RESERVED) || !perm_ok
                                || (acc_fetch && sel.xn);
            end else begin
                out_fault     = !acc_priv;
            end
        end
    end

endmodule

// File: rtl/mpu_region_check.sv
// Top of the protection region checker: register file, per-region match,
// resolve/decode, and one output register stage. Assumes NUM_REGIONS >= 2.
module mpu_region_check
    import mpu_pkg::*;
#(
    parameter int NUM_REGIONS = 8,
    localparam int IDX_W      = $clog2(NUM_REGIONS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mpu_enable,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_region,
    input  logic              cfg_field,
    input  logic [31:0]       cfg_wdata,
    input  logic              acc_valid,
    input  logic [31:0]       acc_addr,
    input  logic              acc_write,
    input  logic              acc_priv,
    input  logic              acc_fetch,
    output logic              res_valid,
    output logic              res_hit,
    output logic [IDX_W-1:0]  res_region,
    output logic [1:0]        res_mtype,
    output logic              res_shareable,
    output logic              res_fault
);

    region_cfg_t [NUM_REGIONS-1:0] regions;
    logic [NUM_REGIONS-1:0]        hits;
    logic                          c_hit;
    logic [IDX_W-1:0]              c_region;
    mem_type_e                     c_mtype;
    logic                          c_share;
    logic                          c_fault;

    mpu_cfg_regs #(.NUM_REGIONS(NUM_REGIONS), .IDX_W(IDX_W)) i_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_region (cfg_region),
        .cfg_field  (cfg_field),
        .cfg_wdata  (cfg_wdata),
        .regions    (regions)
    );

    for (genvar gm = 0; gm < NUM_REGIONS; gm++) begin : g_match
        mpu_region_match i_match (
            .cfg  (regions[gm]),
            .addr (acc_addr),
            .hit  (hits[gm])
        );
    end

    mpu_attr_check #(.NUM_REGIONS(NUM_REGIONS), .IDX_W(IDX_W)) i_attr (
        .regions       (regions),
        .hits          (hits),
        .enable        (mpu_enable),
        .acc_write     (acc_write),
        .acc_priv      (acc_priv),
        .acc_fetch     (acc_fetch),
        .out_hit       (c_hit),
        .out_region    (c_region),
        .out_mtype     (c_mtype),
        .out_shareable (c_share),
        .out_fault     (c_fault)
    );

    // Register the lookup result one cycle after the access
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid     <= 1'b0;
            res_hit       <= 1'b0;
            res_region    <= '0;
            res_mtype     <= 2'd0;
            res_shareable <= 1'b0;
            res_fault     <= 1'b0;
        end else begin
            res_valid     <= acc_valid;
            res_hit       <= c_hit;
            res_region    <= c_region;
            res_mtype     <= c_mtype;
            res_shareable <= c_share;
            res_fault     <= c_fault;
        end
    end

endmodule

// File: rtl/mpu_region_check_sva.sv
// Port-level properties of the protection region checker, bound to the top.
module mpu_region_check_sva (
    input logic       clk,
    input logic       rst_n,
    input logic       mpu_enable,
    input logic       acc_valid,
    input logic       acc_priv,
    input logic       res_valid,
    input logic       res_hit,
    input logic [1:0] res_mtype,
    input logic       res_shareable,
    input logic       res_fault
);

    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> res_valid);

    assert_idle_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !res_valid);

    assert_off_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && !mpu_enable |=> !res_hit && !res_fault);

    assert_miss_unpriv_R11: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && mpu_enable && !acc_priv |=> res_hit || res_fault);

    assert_miss_priv_R11: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && mpu_enable && acc_priv |=> res_hit || !res_fault);

    assert_reserved_faults_R8: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && res_mtype == 2'd3 |-> res_fault && res_hit);

    assert_strong_shared_R5: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && res_mtype == 2'd2 |-> res_shareable);

endmodule

bind mpu_region_check mpu_region_check_sva i_sva (
    .clk           (clk),
    .rst_n         (rst_n),
    .mpu_enable    (mpu_enable),
    .acc_valid     (acc_valid),
    .acc_priv      (acc_priv),
    .res_valid     (res_valid),
    .res_hit       (res_hit),
    .res_mtype     (res_mtype),
    .res_shareable (res_shareable),
    .res_fault     (res_fault)
);

// File: tb/test_mpu_region_check.sv
`timescale 1ns/1ps
module test_mpu_region_check;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mpu_enable = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_region = '0;
    logic        cfg_field = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic        acc_write = 1'b0;
    logic        acc_priv = 1'b0;
    logic        acc_fetch = 1'b0;
    logic        res_valid, res_hit, res_shareable, res_fault;
    logic [2:0]  res_region;
    logic [1:0]  res_mtype;

    int checks = 0;
    int failures = 0;

    logic [31:0] sh_base [8];
    logic [31:0] sh_attr [8];

    always #10 clk = ~clk;   // 50 MHz

    mpu_region_check i_mpu_region_check (
        .clk(clk), .rst_n(rst_n), .mpu_enable(mpu_enable),
        .cfg_we(cfg_we), .cfg_region(cfg_region), .cfg_field(cfg_field),
        .cfg_wdata(cfg_wdata), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .acc_write(acc_write), .acc_priv(acc_priv), .acc_fetch(acc_fetch),
        .res_valid(res_valid), .res_hit(res_hit), .res_region(res_region),
        .res_mtype(res_mtype), .res_shareable(res_shareable), .res_fault(res_fault)
    );

    task automatic check(input string tag, input logic [8:0] act, input logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] attr_word(logic en, logic [4:0] size, logic [7:0] srd,
        logic [2:0] tex, logic s, logic c, logic b, logic [2:0] ap, logic xn);
        return {3'b0, xn, 1'b0, ap, 2'b0, tex, s, c, b, srd, 2'b0, size, en};
    endfunction

    // Reference model: {valid, hit, region[2:0], mtype[1:0], shareable, fault}
    function automatic logic [8:0] model(logic [31:0] addr, logic wr, logic pv, logic fe, logic en);
        logic hit = 1'b0;
        logic [2:0] win = '0;
        logic [1:0] mt;
        logic sh, flt, w, okr;
        logic [31:0] a;
        logic [3:0] perm;
        if (!en) return {1'b1, 1'b0, 3'd0, 2'd0, 1'b0, 1'b0};
        for (int r = 0; r < 8; r++) begin
            logic [63:0] span, lo, ad;
            logic [4:0] s;
            a = sh_attr[r];
            if (!a[0]) continue;
            s = a[5:1];
            span = 64'd1 << (s + 1);
            lo = {32'd0, sh_base[r] & 32'hFFFF_FFE0} & ~(span - 64'd1);
            ad = {32'd0, addr};
            if (ad >= lo && ad < lo + span) begin
                if (s >= 7 && a[8 + int'((ad - lo) / (span >> 3))]) continue;
                hit = 1'b1;
                win = 3'(r);
            end
        end
        if (!hit) return {1'b1, 1'b0, 3'd0, 2'd0, 1'b0, !pv};
        a = sh_attr[win];
        casez ({a[21:19], a[17], a[16]})
            5'b1????:       begin mt = 2'd0; sh = a[18]; end
            5'b00000:       begin mt = 2'd2; sh = 1'b1; end
            5'b00001:       begin mt = 2'd1; sh = 1'b1; end
            5'b0001?:       begin mt = 2'd0; sh = a[18]; end
            5'b00100,
            5'b00111:       begin mt = 2'd0; sh = a[18]; end
            5'b01000:       begin mt = 2'd1; sh = 1'b0; end
            default:        begin mt = 2'd3; sh = 1'b0; end
        endcase
        // {priv read, priv write, user read, user write}
        case (a[26:24])
            3'd1: perm = 4'b1100;
            3'd2: perm = 4'b1110;
            3'd3: perm = 4'b1111;
            3'd5: perm = 4'b1000;
            3'd6, 3'd7: perm = 4'b1010;
            default: perm = 4'b0000;
        endcase
        w = wr && !fe;
        okr = pv ? (w ? perm[2] : perm[3]) : (w ? perm[0] : perm[1]);
        flt = (mt == 2'd3) || !okr || (fe && a[28]);
        return {1'b1, 1'b1, win, mt, sh, flt};
    endfunction

    task automatic wr_cfg(input logic [2:0] r, input logic f, input logic [31:0] d);
        cfg_we = 1'b1; cfg_region = r; cfg_field = f; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (f) sh_attr[r] = d; else sh_base[r] = d;
    endtask

    task automatic access(input logic [31:0] ad, input logic w, input logic p,
                          input logic f, input string tag);
        logic [8:0] exp;
        acc_valid = 1'b1; acc_addr = ad; acc_write = w; acc_priv = p; acc_fetch = f;
        exp = model(ad, w, p, f, mpu_enable);
        @(negedge clk);
        acc_valid = 1'b0;
        check(tag, {res_valid, res_hit, res_region, res_mtype, res_shareable, res_fault}, exp);
    endtask

    initial begin
        #3_000_000;
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240607));
        for (int r = 0; r < 8; r++) begin sh_base[r] = '0; sh_attr[r] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R14: reset state
        check("R14 reset outputs",
              {res_valid, res_hit, res_region, res_mtype, res_shareable, res_fault}, 9'd0);
        mpu_enable = 1'b1;
        access(32'h1000_0000, 1'b0, 1'b1, 1'b0, "R14 regions off priv");
        access(32'h1000_0000, 1'b0, 1'b0, 1'b0, "R11 miss unpriv");

        // R1/R4: 512 KB region with lowest 128 KB masked over a 128 KB region
        wr_cfg(3'd5, 1'b0, 32'h2000_0000);
        wr_cfg(3'd5, 1'b1, attr_word(1, 5'd18, 8'h03, 3'b000, 0, 0, 1, 3'd3, 0));
        wr_cfg(3'd2, 1'b0, 32'h2000_001F);
        wr_cfg(3'd2, 1'b1, attr_word(1, 5'd16, 8'h00, 3'b001, 1, 1, 1, 3'd3, 0));
        access(32'h2000_1000, 1'b0, 1'b1, 1'b0, "R4 masked eighth low");
        check("R4 region2 wins", {6'd0, res_region}, 9'd2);
        access(32'h2001_FFFC, 1'b0, 1'b1, 1'b0, "R4 masked eighth top");
        access(32'h2002_0000, 1'b0, 1'b1, 1'b0, "R4 unmasked eighth");
        check("R4 region5 wins", {6'd0, res_region}, 9'd5);
        access(32'h2007_FFFF, 1'b1, 1'b1, 1'b0, "R1 region end");
        access(32'h2008_0000, 1'b0, 1'b1, 1'b0, "R1 past region end");
        // R4: mask ignored below 256 bytes
        wr_cfg(3'd6, 1'b0, 32'h3000_0000);
        wr_cfg(3'd6, 1'b1, attr_word(1, 5'd5, 8'hFF, 3'b000, 0, 1, 0, 3'd3, 0));
        access(32'h3000_0010, 1'b0, 1'b0, 1'b0, "R4 small region mask ignored");
        check("R4 small region hit", {8'd0, res_hit}, 9'd1);
        // R3: higher region overlapping
        wr_cfg(3'd7, 1'b0, 32'h2000_0000);
        wr_cfg(3'd7, 1'b1, attr_word(1, 5'd11, 8'h00, 3'b010, 0, 0, 0, 3'd6, 1));
        access(32'h2000_0100, 1'b0, 1'b1, 1'b0, "R3 highest region wins");
        check("R3 region7", {6'd0, res_region}, 9'd7);
        // R12: unit off
        mpu_enable = 1'b0;
        access(32'h2000_0100, 1'b1, 1'b0, 1'b1, "R12 unit off");
        mpu_enable = 1'b1;

        // R5 R6 R7 R8: full TEX/C/B/S sweep in region 0
        wr_cfg(3'd0, 1'b0, 32'h4000_0000);
        for (int k = 0; k < 64; k++) begin
            logic [5:0] v = 6'(k);
            wr_cfg(3'd0, 1'b1, attr_word(1, 5'd10, 8'h00, v[5:3], v[2], v[1], v[0], 3'd3, 0));
            access(32'h4000_0040, 1'b0, 1'b1, 1'b0, "R5 R6 R7 R8 attr decode");
        end
        // R9: AP table
        for (int ap = 0; ap < 8; ap++) begin
            wr_cfg(3'd0, 1'b1, attr_word(1, 5'd10, 8'h00, 3'b100, 0, 0, 0, 3'(ap), 0));
            for (int m = 0; m < 4; m++)
                access(32'h4000_0080, m[0], m[1], 1'b0, "R9 permission");
            access(32'h4000_0080, 1'b1, 1'b0, 1'b1, "R9 fetch counts as read");
        end
        // R10: execute-never
        wr_cfg(3'd0, 1'b1, attr_word(1, 5'd10, 8'h00, 3'b100, 0, 0, 0, 3'd3, 1));
        access(32'h4000_0000, 1'b0, 1'b1, 1'b1, "R10 fetch XN");
        check("R10 fault", {8'd0, res_fault}, 9'd1);
        access(32'h4000_0000, 1'b0, 1'b1, 1'b0, "R10 data read XN");
        wr_cfg(3'd0, 1'b1, attr_word(1, 5'd10, 8'h00, 3'b100, 0, 0, 0, 3'd3, 0));
        access(32'h4000_0000, 1'b0, 0, 1'b1, "R10 fetch no XN");

        // R13: write and access in the same cycle
        begin
            logic [8:0] exp;
            acc_valid = 1'b1; acc_addr = 32'h4000_0000; acc_write = 1'b0;
            acc_priv = 1'b1; acc_fetch = 1'b0;
            cfg_we = 1'b1; cfg_region = 3'd0; cfg_field = 1'b1; cfg_wdata = 32'h0;
            exp = model(32'h4000_0000, 1'b0, 1'b1, 1'b0, 1'b1);
            @(negedge clk);
            cfg_we = 1'b0; acc_valid = 1'b0; sh_attr[0] = 32'h0;
            check("R13 old settings used",
                  {res_valid, res_hit, res_region, res_mtype, res_shareable, res_fault}, exp);
            access(32'h4000_0000, 1'b0, 1'b1, 1'b0, "R13 new settings next");
            check("R13 now miss", {8'd0, res_hit}, 9'd0);
        end
        // R2: idle cycle gives no valid result
        @(negedge clk);
        check("R2 no access no result", {8'd0, res_valid}, 9'd0);

        // Random rounds with overlapping regions
        for (int rnd = 0; rnd < 40; rnd++) begin
            for (int q = 0; q < 3; q++) begin
                logic [2:0] r = 3'($urandom_range(0, 7));
                logic [7:0] srd = ($urandom_range(0, 1) != 0) ? 8'($urandom) : 8'h00;
                wr_cfg(r, 1'b0, $urandom & 32'h003F_FFFF);
                wr_cfg(r, 1'b1, attr_word($urandom_range(0, 4) != 0, 5'($urandom_range(4, 20)),
                       srd, 3'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                       3'($urandom), 1'($urandom)));
            end
            mpu_enable = ($urandom_range(0, 9) != 0);
            for (int q = 0; q < 8; q++) begin
                logic f = 1'($urandom);
                access($urandom & 32'h007F_FFFF, f ? 1'b0 : 1'($urandom), 1'($urandom), f,
                       "R1 R3 R4 R9 R11 random");
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule